// File: doc/BRIEF.md
# Snooping Cache Bus Slave

This block watches a phased memory bus for one cache while another agent is master. A transaction opens with a pulse on the phase strobe that carries an opcode and a 24-bit real-address argument. The slave decodes the opcode and compares the argument against every line of its cache. Depending on the outcome it supplies the line's two words, takes in new words, raises the shared line, or updates line flags. It drops its done output for one cycle after every phase strobe so that the master can step the bus forward.

Sharing is tracked per line. Page-dirty status is written to every line of the same real page. A slave that missed keeps counting the phases of the transaction, so it never mistakes a later phase for the start of a new transaction. The line array sits inside the block. A fill port stands for the cache's own writes, and a peek port lets the rest of the cache read the tags, flags and words.

Top module: `snoop_slave`

## Requirements
- R1: After synchronous reset, done_o is 1, shared_o and data_oe_o are 0, data_o is 0, and every line's page, offset, flags and words read back as zero.
- R2: The argument holds the real page in bits [23:8] and the block offset in bits [7:0]. A line hits only when its real-valid flag (flag bit 1) is set and both its page and its offset equal the argument. When several lines hit, the lowest index is chosen.
- R3: done_o is 0 in the cycle that follows every phase strobe and is 1 in every other cycle.
- R4: Fetch (opcode 1) on a hit raises shared_o from the first phase onward. It drives word 0 in phase 2 and word 1 in phase 3, each valid from the cycle after that phase's strobe. It sets the line's shared flag (bit 3) when phase 3 begins.
- R5: Store (opcode 2) on a hit clears the line's line-dirty flag (bit 2). It writes bus_wdata_i, sampled with the strobes of phases 2 and 3, into word 0 and word 1, and it never drives data.
- R6: SFetch (opcode 3) on a hit sets line-dirty and raises shared_o. It drives word 0 and word 1 in phases 2 and 3, then writes the data sampled with the strobes of phases 4 and 5 into word 0 and word 1.
- R7: Store and SFetch set the page-dirty flag (bit 4) on every line whose page equals the argument's page, whatever its valid flags and whether or not the line hit.
- R8: On a miss the slave raises no shared line, drives no data (data_o is 0) and counts 3 phases. For an SFetch miss with shared_i high at the phase-2 strobe it counts 5 phases. Strobes inside the counted phases never open a new transaction, whatever opcode they carry.
- R9: InvalidateVp (opcode 5) clears the virtual-valid flag (bit 0), and InvalidateRp (opcode 6) clears the real-valid flag, of every line whose page equals the argument's page. Both finish in one phase.
- R10: SetMapDirty (opcode 4) lasts 1 phase and WriteMapFlags (opcode 9) lasts 3. WriteMap (opcode 7) and ReadMap (opcode 8) last 2, or 1 if exc_i is high during phase 1. None of them changes a line.
- R11: A fill writes the addressed line's page, offset, flags and words at the clock edge and overrides any snoop update to that line in the same cycle. The peek outputs show the line chosen by peek_idx_i with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_phase_i | input | 1 | One-cycle phase strobe from the bus master |
| bus_op_i | input | 4 | Transaction opcode, read at a transaction's first strobe |
| bus_arg_i | input | 24 | Real page and block offset argument |
| bus_wdata_i | input | 32 | Bus data, sampled with a phase strobe |
| shared_i | input | 1 | Shared line as driven by the other agents |
| exc_i | input | 1 | Bus exception raised during a phase |
| done_o | output | 1 | This slave has finished its part of the current phase |
| shared_o | output | 1 | This slave holds the addressed line |
| data_oe_o | output | 1 | This slave drives data_o onto the bus |
| data_o | output | 32 | Line word being supplied |
| fill_en_i | input | 1 | Write one line from the cache side |
| fill_idx_i | input | 2 | Line index for the fill |
| fill_arg_i | input | 24 | Page and offset for the fill |
| fill_flags_i | input | 5 | Flags for the fill: bit0 virtual-valid, bit1 real-valid, bit2 line-dirty, bit3 shared, bit4 page-dirty |
| fill_w0_i | input | 32 | Word 0 for the fill |
| fill_w1_i | input | 32 | Word 1 for the fill |
| peek_idx_i | input | 2 | Line index to read back |
| peek_arg_o | output | 24 | Page and offset of the line being read |
| peek_flags_o | output | 5 | Flags of the line being read |
| peek_w0_o | output | 32 | Word 0 of the line being read |
| peek_w1_o | output | 32 | Word 1 of the line being read |

## Verification
The bench uses the default parameters: four lines, a 16-bit page and an 8-bit offset. With four lines it can place three lines on one page, one line on another page, and one line with its real-valid flag clear, so each page-wide sweep has to touch some lines and skip others. A later fill makes two lines match the same argument, which exercises the lowest-index rule. During every sit-out phase the bench drives an opcode and argument that would hit, so a slave that counts phases wrongly shows it at once on shared_o.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [3:0] {
        OP_NONE            = 4'd0,
        OP_FETCH           = 4'd1,
        OP_STORE           = 4'd2,
        OP_SFETCH          = 4'd3,
        OP_SET_MAP_DIRTY   = 4'd4,
        OP_INV_VP          = 4'd5,
        OP_INV_RP          = 4'd6,
        OP_WRITE_MAP       = 4'd7,
        OP_READ_MAP        = 4'd8,
        OP_WRITE_MAP_FLAGS = 4'd9
    } bus_op_e;

    // Bit 0 virtual-valid ... bit 4 page-dirty
    typedef struct packed {
        logic pg_dirty;
        logic shared;
        logic ln_dirty;
        logic rvalid;
        logic vvalid;
    } line_flags_t;

    localparam logic [2:0] EXT_PHASES = 3'd5;

    // Number of bus phases this slave takes part in
    function automatic logic [2:0] phase_count(bus_op_e op, logic hit);
        case (op)
            OP_FETCH, OP_STORE:              return 3'd3;
            OP_SFETCH:                       return hit ? 3'd5 : 3'd3;
            OP_WRITE_MAP, OP_READ_MAP:       return 3'd2;
            OP_WRITE_MAP_FLAGS:              return 3'd3;
            default:                         return 3'd1;
        endcase
    endfunction

    function automatic logic drives_line(bus_op_e op);
        return (op == OP_FETCH) || (op == OP_SFETCH);
    endfunction

    function automatic logic marks_page(bus_op_e op);
        return (op == OP_STORE) || (op == OP_SFETCH);
    endfunction

endpackage

// File: rtl/snoop_match.sv
module snoop_match
    import snoop_pkg::*;
#(
    parameter int unsigned LINES  = 4,
    parameter int unsigned PAGE_W = 16,
    parameter int unsigned OFF_W  = 8,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned ARG_W = PAGE_W + OFF_W
) (
    input  logic [ARG_W-1:0]  arg_i,
    input  logic [PAGE_W-1:0] page_i [LINES],
    input  logic [OFF_W-1:0]  off_i  [LINES],
    input  logic [LINES-1:0]  rvalid_i,
    output logic [LINES-1:0]  page_hit_o,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [LINES-1:0] line_hit;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign page_hit_o[g] = (page_i[g] == arg_i[ARG_W-1:OFF_W]);
        assign line_hit[g]   = page_hit_o[g] && rvalid_i[g] &&
                               (off_i[g] == arg_i[OFF_W-1:0]);
    end

    // Lowest index wins
    always_comb begin
        hit_o = |line_hit;
        idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (line_hit[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/snoop_seq.sv
module snoop_seq
    import snoop_pkg::*;
#(
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             new_phase_i,
    input  bus_op_e          op_i,
    input  logic             exc_i,
    input  logic             shared_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             start_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             wr0_o,
    output logic             wr1_o,
    output logic             set_sh_o,
    output logic             done_o,
    output logic             shared_o,
    output logic             data_oe_o,
    output logic             data_sel_o
);
    bus_op_e    op_q;
    logic       hit_q;
    logic [2:0] phase_q;
    logic [2:0] last_q;
    logic [2:0] nxt;
    logic       adv;
    logic       map_op;

    assign start_o  = new_phase_i && ((phase_q == 3'd0) || (phase_q == last_q));
    assign adv      = new_phase_i && !start_o;
    assign nxt      = 3'(phase_q + 3'd1);
    assign map_op   = (op_q == OP_WRITE_MAP) || (op_q == OP_READ_MAP);
    assign idx_o    = idx_q;

    logic [IDX_W-1:0] idx_q;

    assign wr0_o    = adv && hit_q &&
                      (((op_q == OP_STORE)  && (phase_q == 3'd1)) ||
                       ((op_q == OP_SFETCH) && (phase_q == 3'd3)));
    assign wr1_o    = adv && hit_q &&
                      (((op_q == OP_STORE)  && (phase_q == 3'd2)) ||
                       ((op_q == OP_SFETCH) && (phase_q == 3'd4)));
    assign set_sh_o = adv && hit_q && (op_q == OP_FETCH) && (phase_q == 3'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q       <= OP_NONE;
            hit_q      <= 1'b0;
            idx_q      <= '0;
            phase_q    <= 3'd0;
            last_q     <= 3'd0;
            done_o     <= 1'b1;
            shared_o   <= 1'b0;
            data_oe_o  <= 1'b0;
            data_sel_o <= 1'b0;
        end else begin
            done_o <= !new_phase_i;
            if (start_o) begin
                op_q       <= op_i;
                hit_q      <= hit_i;
                idx_q      <= idx_i;
                phase_q    <= 3'd1;
                last_q     <= phase_count(op_i, hit_i);
                shared_o   <= hit_i && drives_line(op_i);
                data_oe_o  <= 1'b0;
                data_sel_o <= 1'b0;
            end else if (adv) begin
                phase_q    <= nxt;
                data_oe_o  <= hit_q && drives_line(op_q) &&
                              ((nxt == 3'd2) || (nxt == 3'd3));
                data_sel_o <= (nxt == 3'd3);
                if ((op_q == OP_SFETCH) && !hit_q && (nxt == 3'd2) && shared_i)
                    last_q <= EXT_PHASES;
            end else if ((phase_q == 3'd1) && map_op && exc_i) begin
                last_q <= 3'd1;
            end
        end
    end
endmodule

// File: rtl/snoop_lines.sv
module snoop_lines
    import snoop_pkg::*;
#(
    parameter int unsigned LINES  = 4,
    parameter int unsigned PAGE_W = 16,
    parameter int unsigned OFF_W  = 8,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned ARG_W = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  bus_op_e           op_i,
    input  logic [LINES-1:0]  page_hit_i,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  hit_idx_i,
    input  logic [IDX_W-1:0]  upd_idx_i,
    input  logic              wr0_i,
    input  logic              wr1_i,
    input  logic              set_sh_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              fill_en_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    input  logic [ARG_W-1:0]  fill_arg_i,
    input  line_flags_t       fill_flags_i,
    input  logic [WORD_W-1:0] fill_w0_i,
    input  logic [WORD_W-1:0] fill_w1_i,
    output logic [PAGE_W-1:0] page_o [LINES],
    output logic [OFF_W-1:0]  off_o  [LINES],
    output logic [LINES-1:0]  rvalid_o,
    output logic [WORD_W-1:0] rd_w0_o,
    output logic [WORD_W-1:0] rd_w1_o,
    input  logic [IDX_W-1:0]  peek_idx_i,
    output logic [ARG_W-1:0]  peek_arg_o,
    output line_flags_t       peek_flags_o,
    output logic [WORD_W-1:0] peek_w0_o,
    output logic [WORD_W-1:0] peek_w1_o
);
    line_flags_t       flags [LINES];
    logic [WORD_W-1:0] w0    [LINES];
    logic [WORD_W-1:0] w1    [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_rv
        assign rvalid_o[g] = flags[g].rvalid;
    end

    assign rd_w0_o      = w0[upd_idx_i];
    assign rd_w1_o      = w1[upd_idx_i];
    assign peek_arg_o   = {page_o[peek_idx_i], off_o[peek_idx_i]};
    assign peek_flags_o = flags[peek_idx_i];
    assign peek_w0_o    = w0[peek_idx_i];
    assign peek_w1_o    = w1[peek_idx_i];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (rst) begin
                page_o[i] <= '0;
                off_o[i]  <= '0;
                flags[i]  <= '0;
                w0[i]     <= '0;
                w1[i]     <= '0;
            end else begin
                if (start_i) begin
                    if (marks_page(op_i) && page_hit_i[i])
                        flags[i].pg_dirty <= 1'b1;
                    if (hit_i && (hit_idx_i == IDX_W'(i))) begin
                        if (op_i == OP_STORE)  flags[i].ln_dirty <= 1'b0;
                        if (op_i == OP_SFETCH) flags[i].ln_dirty <= 1'b1;
                    end
                    if ((op_i == OP_INV_VP) && page_hit_i[i]) flags[i].vvalid <= 1'b0;
                    if ((op_i == OP_INV_RP) && page_hit_i[i]) flags[i].rvalid <= 1'b0;
                end
                if (upd_idx_i == IDX_W'(i)) begin
                    if (set_sh_i) flags[i].shared <= 1'b1;
                    if (wr0_i)    w0[i] <= wdata_i;
                    if (wr1_i)    w1[i] <= wdata_i;
                end
                if (fill_en_i && (fill_idx_i == IDX_W'(i))) begin
                    page_o[i] <= fill_arg_i[ARG_W-1:OFF_W];
                    off_o[i]  <= fill_arg_i[OFF_W-1:0];
                    flags[i]  <= fill_flags_i;
                    w0[i]     <= fill_w0_i;
                    w1[i]     <= fill_w1_i;
                end
            end
        end
    end
endmodule

// File: rtl/snoop_slave.sv
module snoop_slave
    import snoop_pkg::*;
#(
    parameter int unsigned LINES  = 4,
    parameter int unsigned PAGE_W = 16,
    parameter int unsigned OFF_W  = 8,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned ARG_W = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              new_phase_i,
    input  logic [3:0]        bus_op_i,
    input  logic [ARG_W-1:0]  bus_arg_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    input  logic              shared_i,
    input  logic              exc_i,
    output logic              done_o,
    output logic              shared_o,
    output logic              data_oe_o,
    output logic [WORD_W-1:0] data_o,
    input  logic              fill_en_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    input  logic [ARG_W-1:0]  fill_arg_i,
    input  logic [4:0]        fill_flags_i,
    input  logic [WORD_W-1:0] fill_w0_i,
    input  logic [WORD_W-1:0] fill_w1_i,
    input  logic [IDX_W-1:0]  peek_idx_i,
    output logic [ARG_W-1:0]  peek_arg_o,
    output logic [4:0]        peek_flags_o,
    output logic [WORD_W-1:0] peek_w0_o,
    output logic [WORD_W-1:0] peek_w1_o
);
    bus_op_e           op_in;
    logic [PAGE_W-1:0] line_page [LINES];
    logic [OFF_W-1:0]  line_off  [LINES];
    logic [LINES-1:0]  line_rv;
    logic [LINES-1:0]  page_hit;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              start;
    logic [IDX_W-1:0]  cur_idx;
    logic              wr0_w, wr1_w, set_sh_w;
    logic              data_sel;
    logic [WORD_W-1:0] rd_w0, rd_w1;
    line_flags_t       peek_fl;

    assign op_in = bus_op_e'(bus_op_i);

    snoop_match #(.LINES(LINES), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_match (
        .arg_i      (bus_arg_i),
        .page_i     (line_page),
        .off_i      (line_off),
        .rvalid_i   (line_rv),
        .page_hit_o (page_hit),
        .hit_o      (hit),
        .idx_o      (hit_idx)
    );

    snoop_seq #(.IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .new_phase_i(new_phase_i),
        .op_i       (op_in),
        .exc_i      (exc_i),
        .shared_i   (shared_i),
        .hit_i      (hit),
        .idx_i      (hit_idx),
        .start_o    (start),
        .idx_o      (cur_idx),
        .wr0_o      (wr0_w),
        .wr1_o      (wr1_w),
        .set_sh_o   (set_sh_w),
        .done_o     (done_o),
        .shared_o   (shared_o),
        .data_oe_o  (data_oe_o),
        .data_sel_o (data_sel)
    );

    snoop_lines #(.LINES(LINES), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_lines (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .op_i        (op_in),
        .page_hit_i  (page_hit),
        .hit_i       (hit),
        .hit_idx_i   (hit_idx),
        .upd_idx_i   (cur_idx),
        .wr0_i       (wr0_w),
        .wr1_i       (wr1_w),
        .set_sh_i    (set_sh_w),
        .wdata_i     (bus_wdata_i),
        .fill_en_i   (fill_en_i),
        .fill_idx_i  (fill_idx_i),
        .fill_arg_i  (fill_arg_i),
        .fill_flags_i(line_flags_t'(fill_flags_i)),
        .fill_w0_i   (fill_w0_i),
        .fill_w1_i   (fill_w1_i),
        .page_o      (line_page),
        .off_o       (line_off),
        .rvalid_o    (line_rv),
        .rd_w0_o     (rd_w0),
        .rd_w1_o     (rd_w1),
        .peek_idx_i  (peek_idx_i),
        .peek_arg_o  (peek_arg_o),
        .peek_flags_o(peek_fl),
        .peek_w0_o   (peek_w0_o),
        .peek_w1_o   (peek_w1_o)
    );

    assign peek_flags_o = peek_fl;
    assign data_o       = data_oe_o ? (data_sel ? rd_w1 : rd_w0) : '0;
endmodule

// File: rtl/snoop_slave_chk.sv
module snoop_slave_chk (
    input logic clk,
    input logic rst,
    input logic new_phase_i,
    input logic done_o,
    input logic shared_o,
    input logic data_oe_o,
    input logic wr0,
    input logic wr1,
    input logic set_sh
);
    assert_done_drop_R3: assert property (@(posedge clk) disable iff (rst)
        new_phase_i |=> !done_o);

    assert_data_needs_shared_R4: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> shared_o);

    assert_drive_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe_o) |-> $past(new_phase_i));

    assert_drive_steady_R4: assert property (@(posedge clk) disable iff (rst)
        !new_phase_i |=> $stable(data_oe_o));

    assert_shared_drop_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(shared_o) |-> $past(new_phase_i));

    assert_one_line_update_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr0, wr1, set_sh}));
endmodule

bind snoop_slave snoop_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .new_phase_i(new_phase_i),
    .done_o     (done_o),
    .shared_o   (shared_o),
    .data_oe_o  (data_oe_o),
    .wr0        (wr0_w),
    .wr1        (wr1_w),
    .set_sh     (set_sh_w)
);

// File: tb/tb_snoop_slave.sv
module tb_snoop_slave;
    localparam logic [4:0] VV = 5'd1, RV = 5'd2, LD = 5'd4, SH = 5'd8, PD = 5'd16;
    localparam logic [3:0] FETCH = 4'd1, STORE = 4'd2, SFETCH = 4'd3, SMD = 4'd4,
                           IVP = 4'd5, IRP = 4'd6, WMAP = 4'd7, RMAP = 4'd8, WMF = 4'd9;

    logic        clk = 1'b0, rst = 1'b1;
    logic        new_phase = 1'b0, shared_in = 1'b0, exc = 1'b0;
    logic [3:0]  bus_op = '0;
    logic [23:0] bus_arg = '0;
    logic [31:0] bus_wdata = '0;
    logic        done_o, shared_o, data_oe_o;
    logic [31:0] data_o;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_idx = '0, peek_idx = '0;
    logic [23:0] fill_arg = '0, peek_arg;
    logic [4:0]  fill_flags = '0, peek_flags;
    logic [31:0] fill_w0 = '0, fill_w1 = '0, peek_w0, peek_w1;

    int n_chk = 0, n_err = 0;
    bit live = 1'b0, finished = 1'b0;
    logic np_seen = 1'b0;

    logic [23:0] m_arg [4];
    logic [4:0]  m_fl  [4];
    logic [31:0] m_w0  [4];
    logic [31:0] m_w1  [4];

    always #10 clk = ~clk;

    snoop_slave dut (
        .clk(clk), .rst(rst), .new_phase_i(new_phase), .bus_op_i(bus_op),
        .bus_arg_i(bus_arg), .bus_wdata_i(bus_wdata), .shared_i(shared_in),
        .exc_i(exc), .done_o(done_o), .shared_o(shared_o), .data_oe_o(data_oe_o),
        .data_o(data_o), .fill_en_i(fill_en), .fill_idx_i(fill_idx),
        .fill_arg_i(fill_arg), .fill_flags_i(fill_flags), .fill_w0_i(fill_w0),
        .fill_w1_i(fill_w1), .peek_idx_i(peek_idx), .peek_arg_o(peek_arg),
        .peek_flags_o(peek_flags), .peek_w0_o(peek_w0), .peek_w1_o(peek_w1)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R3 compared on every clock: done low only after a strobe
    always @(posedge clk) np_seen <= new_phase;
    always @(negedge clk) if (live && !finished) chk("R3 done", done_o, !np_seen);

    task automatic phase(input logic [3:0] op, input logic [23:0] arg,
                         input logic [31:0] wd, input logic sh);
        @(negedge clk);
        new_phase = 1'b1; bus_op = op; bus_arg = arg; bus_wdata = wd; shared_in = sh;
        @(negedge clk);
        new_phase = 1'b0; shared_in = 1'b0;
    endtask

    task automatic fill(input int idx, input logic [23:0] arg, input logic [4:0] fl,
                        input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 2'(idx); fill_arg = arg; fill_flags = fl;
        fill_w0 = a; fill_w1 = b;
        @(negedge clk);
        fill_en = 1'b0;
        m_arg[idx] = arg; m_fl[idx] = fl; m_w0[idx] = a; m_w1[idx] = b;
    endtask

    task automatic check_lines(input string tag);
        for (int i = 0; i < 4; i++) begin
            peek_idx = 2'(i);
            #1;
            chk({tag, " arg"},   peek_arg,   m_arg[i]);
            chk({tag, " flags"}, peek_flags, m_fl[i]);
            chk({tag, " w0"},    peek_w0,    m_w0[i]);
            chk({tag, " w1"},    peek_w1,    m_w1[i]);
        end
    endtask

    task automatic mark_page(input logic [15:0] pg);
        for (int i = 0; i < 4; i++)
            if (m_arg[i][23:8] == pg) m_fl[i] = m_fl[i] | PD;
    endtask

    // Sit-out phase carrying an opcode that would hit line 0 if wrongly started
    task automatic quiet_phase(input string tag);
        phase(FETCH, 24'h1234_10, 32'h0, 1'b0);
        chk({tag, " shared"}, shared_o, 1'b0);
        chk({tag, " oe"}, data_oe_o, 1'b0);
        chk({tag, " data"}, data_o, 32'h0);
    endtask

    // Full Fetch to a line expected to hit with the given words
    task automatic fetch_hit(input string tag, input logic [23:0] arg, input int idx);
        phase(FETCH, arg, 32'h0, 1'b0);
        chk({tag, " shared"}, shared_o, 1'b1);
        phase(4'd0, 24'h0, 32'h0, 1'b0);
        chk({tag, " w0"}, data_o, m_w0[idx]);
        phase(4'd0, 24'h0, 32'h0, 1'b0);
        chk({tag, " w1"}, data_o, m_w1[idx]);
        m_fl[idx] = m_fl[idx] | SH;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_arg[i] = '0; m_fl[i] = '0; m_w0[i] = '0; m_w1[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;
        #1;
        // R1 reset state
        chk("R1 done", done_o, 1'b1);
        chk("R1 shared", shared_o, 1'b0);
        chk("R1 oe", data_oe_o, 1'b0);
        chk("R1 data", data_o, 32'h0);
        check_lines("R1 lines");

        // R11 fill and peek
        fill(0, 24'h1234_10, RV | VV,      32'hA000_0000, 32'hA000_0001);
        fill(1, 24'h1234_20, RV | VV | LD, 32'hB000_0000, 32'hB000_0001);
        fill(2, 24'h5555_10, RV | VV,      32'hC000_0000, 32'hC000_0001);
        fill(3, 24'h1234_30, VV,           32'hD000_0000, 32'hD000_0001);
        check_lines("R11 fill");

        // R4 Fetch hit with phase-by-phase checks
        phase(FETCH, 24'h1234_10, 32'h0, 1'b0);
        chk("R4 shared ph1", shared_o, 1'b1);
        chk("R4 no data ph1", data_oe_o, 1'b0);
        chk("R3 done low", done_o, 1'b0);
        phase(4'd0, 24'h0, 32'h0, 1'b0);
        chk("R4 oe ph2", data_oe_o, 1'b1);
        chk("R4 w0 ph2", data_o, 32'hA000_0000);
        check_lines("R4 shared not yet");
        phase(4'd0, 24'h0, 32'h0, 1'b0);
        chk("R4 w1 ph3", data_o, 32'hA000_0001);
        m_fl[0] = m_fl[0] | SH;
        check_lines("R4 shared flag");

        // R2/R8 miss on line with real-valid clear, 3 phases counted
        phase(FETCH, 24'h1234_30, 32'h0, 1'b0);
        chk("R2 rvalid needed", shared_o, 1'b0);
        chk("R8 miss no data", data_oe_o, 1'b0);
        quiet_phase("R8 fetch miss ph2");
        quiet_phase("R8 fetch miss ph3");
        fetch_hit("R8 after fetch miss", 24'h1234_20, 1);
        check_lines("R4 line1 shared");

        // R5/R7 Store hit on line 1
        phase(STORE, 24'h1234_20, 32'h0, 1'b0);
        chk("R5 no shared", shared_o, 1'b0);
        m_fl[1] = m_fl[1] & ~LD;
        mark_page(16'h1234);
        phase(4'd0, 24'h0, 32'h1111_1111, 1'b0);
        chk("R5 no drive ph2", data_oe_o, 1'b0);
        phase(4'd0, 24'h0, 32'h2222_2222, 1'b0);
        chk("R5 no drive ph3", data_oe_o, 1'b0);
        m_w0[1] = 32'h1111_1111; m_w1[1] = 32'h2222_2222;
        check_lines("R5 R7 store hit");

        // R7/R8 Store miss on page 0x5555
        phase(STORE, 24'h5555_77, 32'h0, 1'b0);
        mark_page(16'h5555);
        phase(4'd0, 24'h0, 32'h9999_9999, 1'b0);
        phase(4'd0, 24'h0, 32'h8888_8888, 1'b0);
        check_lines("R7 R8 store miss");

        // R6 SFetch hit on line 2
        phase(SFETCH, 24'h5555_10, 32'h0, 1'b0);
        chk("R6 shared", shared_o, 1'b1);
        m_fl[2] = m_fl[2] | LD;
        phase(4'd0, 24'h0, 32'h0, 1'b0);
        chk("R6 w0 out", data_o, 32'hC000_0000);
        phase(4'd0, 24'h0, 32'h0, 1'b0);
        chk("R6 w1 out", data_o, 32'hC000_0001);
        phase(4'd0, 24'h0, 32'h3333_3333, 1'b0);
        chk("R6 no drive ph4", data_oe_o, 1'b0);
        phase(4'd0, 24'h0, 32'h4444_4444, 1'b0);
        m_w0[2] = 32'h3333_3333; m_w1[2] = 32'h4444_4444;
        check_lines("R6 sfetch hit");

        // R8 SFetch miss, other agent shares: 5 phases
        phase(SFETCH, 24'h9999_00, 32'h0, 1'b0);
        chk("R8 sfetch miss shared", shared_o, 1'b0);
        @(negedge clk);
        new_phase = 1'b1; bus_op = FETCH; bus_arg = 24'h1234_10; shared_in = 1'b1;
        @(negedge clk);
        new_phase = 1'b0; shared_in = 1'b0;
        chk("R8 ext ph2", shared_o, 1'b0);
        quiet_phase("R8 ext ph3");
        quiet_phase("R8 ext ph4");
        quiet_phase("R8 ext ph5");
        fetch_hit("R8 after ext", 24'h1234_10, 0);

        // R8 SFetch miss without sharing: 3 phases
        phase(SFETCH, 24'h9999_00, 32'h0, 1'b0);
        quiet_phase("R8 plain ph2");
        quiet_phase("R8 plain ph3");
        fetch_hit("R8 after plain", 24'h1234_10, 0);
        check_lines("R8 no side effects");

        // R9 invalidations
        phase(IVP, 24'h1234_00, 32'h0, 1'b0);
        for (int i = 0; i < 4; i++)
            if (m_arg[i][23:8] == 16'h1234) m_fl[i] = m_fl[i] & ~VV;
        check_lines("R9 inv vp");
        phase(IRP, 24'h5555_00, 32'h0, 1'b0);
        m_fl[2] = m_fl[2] & ~RV;
        check_lines("R9 inv rp");

        // R10 map operations and phase counts
        phase(SMD, 24'h1234_00, 32'h0, 1'b0);
        fetch_hit("R10 after set-map-dirty", 24'h1234_10, 0);
        phase(WMF, 24'h1234_00, 32'h0, 1'b0);
        quiet_phase("R10 wmf ph2");
        quiet_phase("R10 wmf ph3");
        fetch_hit("R10 after wmf", 24'h1234_10, 0);
        phase(WMAP, 24'h1234_00, 32'h0, 1'b0);
        quiet_phase("R10 wmap ph2");
        fetch_hit("R10 after wmap", 24'h1234_10, 0);
        phase(RMAP, 24'h1234_00, 32'h0, 1'b0);
        exc = 1'b1;
        @(negedge clk);
        exc = 1'b0;
        fetch_hit("R10 after rmap exc", 24'h1234_10, 0);
        check_lines("R10 lines untouched");

        // R2 lowest index wins on duplicate tags
        fill(3, 24'h1234_10, RV | VV, 32'hE000_0000, 32'hE000_0001);
        fetch_hit("R2 priority", 24'h1234_10, 0);
        check_lines("R2 line3 untouched");

        // R11 fill overrides same-cycle snoop update
        @(negedge clk);
        new_phase = 1'b1; bus_op = IVP; bus_arg = 24'h1234_00;
        fill_en = 1'b1; fill_idx = 2'd1; fill_arg = 24'h1234_20; fill_flags = RV | VV;
        fill_w0 = 32'hF000_0000; fill_w1 = 32'hF000_0001;
        @(negedge clk);
        new_phase = 1'b0; fill_en = 1'b0;
        m_fl[0] = m_fl[0] & ~VV; m_fl[3] = m_fl[3] & ~VV;
        m_arg[1] = 24'h1234_20; m_fl[1] = RV | VV;
        m_w0[1] = 32'hF000_0000; m_w1[1] = 32'hF000_0001;
        check_lines("R11 fill wins");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_err++; n_chk++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule